// File: doc/BRIEF.md
# Banked Dual-Space RAM Arbiter

This block is the on-chip working memory of a processor core. A single RAM is reached from two address spaces at once: an instruction port on the X space, which only reads, and a data port on the Y space, which reads and writes. The RAM is cut into banks of 1024 words each. The bank is picked directly from the address, so reaching a particular bank costs no time.

When the two ports ask for different banks in the same cycle, both are served in that cycle. When they ask for the same bank, the data access goes first. The block raises `stall` for that cycle and serves the fetch in the next cycle. While `stall` is high, the instruction side must keep its request and address unchanged. Read data comes back one cycle after the access is granted, marked by a per-port valid flag.

Top module: `dualspace_bank_arb`

## Requirements
- R1: After reset, `stall`, `i_valid` and `d_valid` are all low until a request is made.
- R2: The bank index is address bits [10 +: log2(NBANKS)] (bit 10 with the default of two banks), and the word within the bank is address bits [9:0]. Address bits above the bank field are ignored, so addresses that differ only there reach the same word.
- R3: When both ports request in a cycle and their bank indices differ, `stall` stays low and both accesses are served in that cycle.
- R4: When both ports request the same bank in a cycle, `stall` is high in that same cycle, the data access is served, and the fetch is not served (`i_valid` low in the following cycle).
- R5: A fetch held through a collision is served in the cycle after the stall, unless a new same-bank data request collides again. A single collision therefore costs exactly one wait cycle.
- R6: When a data write and a fetch collide on the same word, the fetch that follows returns the newly written value.
- R7: A request on only one of the two ports never raises `stall`, whatever bank it targets.
- R8: Read data appears one cycle after the grant: `i_valid`/`d_valid` go high in the next cycle with the addressed word on `i_rdata`/`d_rdata`. A data write updates the word and never raises `d_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_req | input | 1 | Instruction fetch request |
| i_addr | input | AW | Instruction fetch address (X space) |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a write when high |
| d_addr | input | AW | Data address (Y space) |
| d_wdata | input | DW | Data write value |
| stall | output | 1 | Same-bank collision this cycle; fetch deferred |
| i_rdata | output | DW | Fetched word |
| i_valid | output | 1 | `i_rdata` holds a served fetch |
| d_rdata | output | DW | Data read word |
| d_valid | output | 1 | `d_rdata` holds a served data read |

## Verification
The bench sends collisions with the fetch held through the stall cycle. A design that let the fetch go first, or served it in the same cycle, would return a valid fetch too early or corrupt the data read. A write colliding with a fetch of the same word must hand the new value to the deferred fetch; if the order were reversed, the fetch would return the stale word. Aliased addresses that differ only above the bank field expose a bank decode that uses the wrong bits. Long runs of single-port traffic catch a stall raised without a second requester.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  // Word-select width inside one bank (1024 words per bank)
  localparam int WORD_BITS = 10;
  localparam int BANK_WORDS = 1 << WORD_BITS;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bank_arb_ctl.sv
module bank_arb_ctl #(
  parameter int NBANKS = 2,
  parameter int BSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              i_req,
  input  logic [BSEL_W-1:0] i_bank,
  input  logic              d_req,
  input  logic [BSEL_W-1:0] d_bank,
  output logic              stall,
  output logic              i_go,
  output logic [NBANKS-1:0] sel_d,
  output logic [NBANKS-1:0] sel_i
);
  logic collide;

  always_comb begin
    collide = i_req && d_req && (i_bank == d_bank);
    stall   = collide;
    i_go    = i_req && !collide;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_sel
    always_comb begin
      sel_d[b] = d_req && (d_bank == BSEL_W'(b));
      sel_i[b] = i_go  && (i_bank == BSEL_W'(b));
    end
  end

  AST_SINGLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_req != d_req) |-> !stall); // R7
  AST_BANK_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(sel_d & sel_i) == 0); // R4
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DW = 16,
  parameter int WBITS = 10
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [WBITS-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [1 << WBITS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we)  mem[addr] <= wdata;
    if (en && !we) rdata_q   <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dualspace_bank_arb.sv
module dualspace_bank_arb
  import bank_arb_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int NBANKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_req,
  input  logic [AW-1:0] i_addr,
  input  logic          d_req,
  input  logic          d_we,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  output logic          stall,
  output logic [DW-1:0] i_rdata,
  output logic          i_valid,
  output logic [DW-1:0] d_rdata,
  output logic          d_valid
);
  localparam int BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int HI_LSB = WORD_BITS + BSEL_W;

  logic rst_sync_n;
  logic [BSEL_W-1:0] i_bank, d_bank;
  logic i_go;
  logic [NBANKS-1:0] sel_d, sel_i;
  logic [DW-1:0] bank_rd [NBANKS];

  logic i_valid_q, i_valid_d, d_valid_q, d_valid_d;
  logic [BSEL_W-1:0] i_bank_q, i_bank_d, d_bank_q, d_bank_d;

  logic unused_hi;
  assign unused_hi = ^{i_addr[AW-1:HI_LSB], d_addr[AW-1:HI_LSB]};

  arb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    i_bank = i_addr[WORD_BITS +: BSEL_W];
    d_bank = d_addr[WORD_BITS +: BSEL_W];
  end

  bank_arb_ctl #(.NBANKS(NBANKS), .BSEL_W(BSEL_W)) u_ctl (
    .clk(clk), .rst_sync_n(rst_sync_n),
    .i_req(i_req), .i_bank(i_bank), .d_req(d_req), .d_bank(d_bank),
    .stall(stall), .i_go(i_go), .sel_d(sel_d), .sel_i(sel_i)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic              b_en, b_we;
    logic [WORD_BITS-1:0] b_addr;
    always_comb begin
      b_en   = sel_d[b] || sel_i[b];
      b_we   = sel_d[b] && d_we;
      b_addr = sel_d[b] ? d_addr[WORD_BITS-1:0] : i_addr[WORD_BITS-1:0];
    end
    ram_bank #(.DW(DW), .WBITS(WORD_BITS)) u_ram (
      .clk(clk), .en(b_en), .we(b_we), .addr(b_addr),
      .wdata(d_wdata), .rdata(bank_rd[b])
    );
  end

  // Next-state for return path
  always_comb begin
    i_valid_d = i_go;
    d_valid_d = d_req && !d_we;
    i_bank_d  = i_go ? i_bank : i_bank_q;
    d_bank_d  = d_valid_d ? d_bank : d_bank_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      i_valid_q <= 1'b0;
      d_valid_q <= 1'b0;
      i_bank_q  <= '0;
      d_bank_q  <= '0;
    end else begin
      i_valid_q <= i_valid_d;
      d_valid_q <= d_valid_d;
      i_bank_q  <= i_bank_d;
      d_bank_q  <= d_bank_d;
    end
  end

  assign i_valid = i_valid_q;
  assign d_valid = d_valid_q;
  assign i_rdata = bank_rd[i_bank_q];
  assign d_rdata = bank_rd[d_bank_q];

  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> !i_valid); // R4
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> (i_req && $stable(i_addr))); // R5
  AST_CROSS_BANK_BOTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_req && d_req && (i_bank != d_bank)) |=> i_valid); // R3
  AST_DREAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (d_req && !d_we) |=> d_valid); // R8
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (d_req && d_we) |=> !d_valid); // R8
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!i_req && !d_req) |=> (!i_valid && !d_valid)); // R1
endmodule

// File: tb/dualspace_bank_arb_test.sv
module dualspace_bank_arb_test;
  logic clk = 1'b0;
  logic rst_n;
  logic i_req, d_req, d_we;
  logic [15:0] i_addr, d_addr, d_wdata;
  logic stall, i_valid, d_valid;
  logic [15:0] i_rdata, d_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit last_stall = 0;
  logic [15:0] model [2048];

  always #5 clk = ~clk;

  dualspace_bank_arb uut (
    .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_addr(i_addr),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .stall(stall), .i_rdata(i_rdata), .i_valid(i_valid),
    .d_rdata(d_rdata), .d_valid(d_valid)
  );

  function automatic int unsigned idx(input logic [15:0] a);
    return {21'd0, a[10:0]};
  endfunction

  function automatic bit same_bank(input logic [15:0] a, input logic [15:0] b);
    return a[10] == b[10];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit ir, input logic [15:0] ia, input bit dr, input bit dw,
                      input logic [15:0] da, input logic [15:0] dd);
    bit exp_st, gi, held;
    logic [15:0] exp_d, exp_i;
    string st_tag;
    exp_d = '0;
    exp_i = '0;
    held = last_stall;
    i_req = ir; i_addr = ia; d_req = dr; d_we = dw; d_addr = da; d_wdata = dd;
    #1;
    exp_st = ir && dr && same_bank(ia, da);
    st_tag = exp_st ? "R4 stall" : ((ir && dr) ? "R3 stall" : "R7 stall");
    check(stall === exp_st, st_tag, {15'd0, stall}, {15'd0, exp_st});
    gi = ir && !exp_st;
    if (dr && !dw) exp_d = model[idx(da)];
    if (dr && dw)  model[idx(da)] = dd;
    if (gi)        exp_i = model[idx(ia)];
    @(posedge clk);
    @(negedge clk);
    check(i_valid === gi, held ? "R5 i_valid" : (exp_st ? "R4 i_valid" : "R3 i_valid"),
          {15'd0, i_valid}, {15'd0, gi});
    check(d_valid === (dr && !dw), "R8 d_valid", {15'd0, d_valid}, {15'd0, dr && !dw});
    if (gi) check(i_rdata === exp_i, "R8 i_rdata", i_rdata, exp_i);
    if (dr && !dw) check(d_rdata === exp_d, "R8 d_rdata", d_rdata, exp_d);
    last_stall = exp_st;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] ia, da;
    bit ir, dr, dw;
    void'($urandom(32'h5eed_1611));
    rst_n = 1'b0;
    i_req = 0; d_req = 0; d_we = 0; i_addr = '0; d_addr = '0; d_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    check(stall === 1'b0, "R1 stall", {15'd0, stall}, 16'd0);
    check(i_valid === 1'b0, "R1 i_valid", {15'd0, i_valid}, 16'd0);
    check(d_valid === 1'b0, "R1 d_valid", {15'd0, d_valid}, 16'd0);

    // Fill every word through the data port (R7: single port never stalls)
    for (int w = 0; w < 2048; w++)
      step(0, '0, 1, 1, 16'(w), 16'($urandom));

    // R2: aliasing through upper address bits
    step(0, '0, 1, 1, 16'h0405, 16'hA5A5);
    step(1, 16'hF405, 0, 0, '0, '0);
    check(i_rdata === 16'hA5A5, "R2 alias fetch", i_rdata, 16'hA5A5);
    step(0, '0, 1, 0, 16'h7805, '0);
    check(d_rdata === model[idx(16'h0005)], "R2 bank0 word", d_rdata, model[5]);

    // R6 + R4 + R5: write and fetch collide on same word
    step(1, 16'h0010, 1, 1, 16'h0010, 16'hBEEF);
    check(i_valid === 1'b0, "R4 deferred fetch", {15'd0, i_valid}, 16'd0);
    step(1, 16'h0010, 0, 0, '0, '0);
    check(i_rdata === 16'hBEEF, "R6 write-first fetch", i_rdata, 16'hBEEF);
    check(i_valid === 1'b1, "R5 one wait", {15'd0, i_valid}, 16'd1);

    // R3: different banks simultaneously, data read and fetch
    step(1, 16'h0400, 1, 0, 16'h0001, '0);

    // Constrained random mix
    ia = '0;
    for (int n = 0; n < 4000; n++) begin
      if (!last_stall) begin
        ir = ($urandom % 4) != 0;
        ia = 16'($urandom);
      end else ir = 1;
      dr = ($urandom % 3) != 0;
      dw = $urandom % 2;
      da = 16'($urandom);
      step(ir, ia, dr, dw, da, 16'($urandom));
    end
    step(0, '0, 0, 0, '0, '0);
    finish_run();
  end
endmodule